// File: doc/BRIEF.md
# Instruction Line Buffer Fill Controller

This block stages instructions between the line-fetch path and the issue stage. It keeps three 128-byte line buffers. One holds the target of a branch hint. The other two hold sequential code. Each line buffer is split into two 64-byte halves, and each half has its own valid flag. A fourth, half-line wide staging buffer feeds issue one instruction pair per fetch. When a fetched line comes back with a target that is not 128-byte aligned, only the words from the target onward count as valid.

The block refills the staging buffer from the sequential halves in address order, alternating between the two sequential buffers. Each such move empties the half it came from. A hint take copies the hint halves in, and the hint buffer keeps its contents. The block issues follow-on sequential line requests and redirect requests, and applies the invalidation events: flush, mispredict clear, hint kill, and a timed kill of sequential content that was older than the last hint take. Branch resolution and hint decoding sit outside the block and arrive as single-cycle strobes.

Top module: `ilbuf_ctrl`

## Requirements
- R1: After reset, pair_valid is 00, req_valid is 0 and prefetch_miss is 1.
- R2: A line loaded with start word k (fill_word) marks only words k..31 valid. If k < 16, both halves are valid. Otherwise only the upper half is valid, and a refill pointed at an invalid lower half takes the upper half of the same buffer. The first pair shown after a refill begins at the even word at or below the first valid word. pair_valid[0] flags the low word of the pair and pair_valid[1] the high word.
- R3: A fetch_req while a pair is shown advances pair_addr by 8 bytes. pair_data holds the low word in bits [31:0] and the high word in [63:32].
- R4: Sequential halves are consumed in the order buffer0 lower, buffer0 upper, buffer1 lower, buffer1 upper, and each consumed half becomes invalid. A refill happens on the same edge that consumes the last pair, so no empty cycle appears when the next half is valid.
- R5: Moving a sequential upper half issues, in the following cycle, a one-cycle request for the next line (line + 1) with word 0 and the tag of the other sequential buffer. Tag encoding: 0 is the hint buffer, 1 is sequential buffer 0, 2 is sequential buffer 1.
- R6: hint_take loads the staging buffer from the hint lower half, or from the upper half if the lower half is invalid. The hint halves stay valid, so a later hint_take shows the same pair again. After the hint upper half, refills continue from sequential buffer 0. The take also requests the line after the hint line, with tag 1 and word 0.
- R7: hint_kill invalidates both hint halves, unless a hint fill arrives in the same cycle.
- R8: flush invalidates every buffer, empties the staging buffer and cancels any request.
- R9: mp_clear invalidates both sequential buffers and leaves the hint buffer intact.
- R10: Sequential content loaded before a hint_take is invalidated on the 8th rising edge after the edge that sampled the take. A refill on that 8th edge still succeeds, and one on the 9th finds the content gone.
- R11: redirect_valid issues, in the next cycle, a request with tag 1, line redirect_addr[17:7] and word redirect_addr[6:2], and points refill at sequential buffer 0 lower half.
- R12: prefetch_miss is 1 whenever the staging buffer is empty or is giving up its last pair and no valid source half is selected. After a miss without a hint take, no pair is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_valid | input | 1 | A fetched line is delivered this cycle |
| fill_tag | input | 2 | Destination buffer of the delivered line |
| fill_line | input | 11 | Line address of the delivered line |
| fill_word | input | 5 | First valid word of the delivered line |
| fill_data | input | 1024 | 32 instruction words, word 0 in the low bits |
| hint_take | input | 1 | Hinted branch entered fetch |
| hint_kill | input | 1 | Newer hint-target request reached the kill stages |
| redirect_valid | input | 1 | Mispredict redirect with corrected address |
| redirect_addr | input | 18 | Corrected byte address |
| mp_clear | input | 1 | Mispredict clear of sequential buffers |
| flush | input | 1 | Pipeline flush |
| fetch_req | input | 1 | Issue consumes the shown pair |
| pair_valid | output | 2 | Valid flags of the low and high word of the pair |
| pair_addr | output | 18 | Byte address of the pair's low word |
| pair_data | output | 64 | Instruction pair |
| prefetch_miss | output | 1 | Refill needed but no valid source |
| req_valid | output | 1 | Line request strobe |
| req_tag | output | 2 | Destination buffer of the request |
| req_line | output | 11 | Requested line address |
| req_word | output | 5 | First word of interest in the requested line |

## Verification
A fill lands in its buffer on the sampling edge. A staging refill from that buffer takes one more edge, so a delivered line shows up as a pair two edges after it is presented. A fetch moves the pair on the next edge, and a refill on the last pair happens on that same edge. Requests are registered and are due in the cycle right after their cause, while prefetch_miss is combinational from the current state. The bench drives inputs and samples outputs only at falling edges. It counts edges for every check, including the exact 8th and 9th edges after a hint take for the timed kill.

// File: rtl/ilbuf_pkg.sv
package ilbuf_pkg;
    typedef enum logic [1:0] {
        TAG_HINT = 2'd0,
        TAG_SEQ0 = 2'd1,
        TAG_SEQ1 = 2'd2
    } buf_tag_e;
endpackage

// File: rtl/ilbuf_line.sv
module ilbuf_line #(
    parameter int DW         = 32,
    parameter int HALF_WORDS = 16,
    parameter int LW         = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [LW-1:0]                 load_line_i,
    input  logic [$clog2(2*HALF_WORDS)-1:0] load_word_i,
    input  logic [2*HALF_WORDS*DW-1:0]    load_data_i,
    input  logic [1:0]                    clr_pre_i,
    input  logic                          clr_post_i,
    input  logic                          mark_stale_i,
    input  logic                          kill_stale_i,
    output logic [1:0]                    valid_o,
    output logic [$clog2(2*HALF_WORDS)-1:0] start_o,
    output logic [LW-1:0]                 line_o,
    output logic [2*HALF_WORDS*DW-1:0]    data_o
);
    localparam int LINE_WORDS = 2 * HALF_WORDS;
    localparam int WB         = $clog2(LINE_WORDS);

    typedef struct packed {
        logic [1:0]               v;
        logic                     stale;
        logic [WB-1:0]            start;
        logic [LW-1:0]            line;
        logic [LINE_WORDS*DW-1:0] data;
    } line_t;

    line_t n_d, n_q;

    always_comb begin
        n_d   = n_q;
        n_d.v = n_q.v & ~clr_pre_i;
        if (kill_stale_i && n_q.stale) begin
            n_d.v     = 2'b00;
            n_d.stale = 1'b0;
        end
        if (load_i) begin
            n_d.v     = {1'b1, ~load_word_i[WB-1]};
            n_d.start = load_word_i;
            n_d.line  = load_line_i;
            n_d.data  = load_data_i;
            n_d.stale = 1'b0;
        end
        if (mark_stale_i) n_d.stale = |n_d.v;
        if (clr_post_i) begin
            n_d.v     = 2'b00;
            n_d.stale = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign valid_o = n_q.v;
    assign start_o = n_q.start;
    assign line_o  = n_q.line;
    assign data_o  = n_q.data;

    // A load always leaves the upper half valid unless a post-clear wins (R2)
    assert_load_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !clr_post_i |=> valid_o[1]);
endmodule

// File: rtl/ilbuf_timer.sv
module ilbuf_timer #(
    parameter int KILL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic flush_i,
    output logic expire_o
);
    localparam int CW = $clog2(KILL_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        if (start_i)     cnt_d = CW'(KILL_CYCLES);
        if (flush_i)     cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == CW'(1));

    // The kill window fires once per take (R10)
    assert_expire_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && !start_i |=> !expire_o);
endmodule

// File: rtl/ilbuf_ctrl.sv
module ilbuf_ctrl
    import ilbuf_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 18,
    parameter int HALF_WORDS  = 16,
    parameter int KILL_CYCLES = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fill_valid,
    input  logic [1:0]                          fill_tag,
    input  logic [AW-$clog2(2*HALF_WORDS)-3:0]  fill_line,
    input  logic [$clog2(2*HALF_WORDS)-1:0]     fill_word,
    input  logic [2*HALF_WORDS*DW-1:0]          fill_data,
    input  logic                                hint_take,
    input  logic                                hint_kill,
    input  logic                                redirect_valid,
    input  logic [AW-1:0]                       redirect_addr,
    input  logic                                mp_clear,
    input  logic                                flush,
    input  logic                                fetch_req,
    output logic [1:0]                          pair_valid,
    output logic [AW-1:0]                       pair_addr,
    output logic [2*DW-1:0]                     pair_data,
    output logic                                prefetch_miss,
    output logic                                req_valid,
    output logic [1:0]                          req_tag,
    output logic [AW-$clog2(2*HALF_WORDS)-3:0]  req_line,
    output logic [$clog2(2*HALF_WORDS)-1:0]     req_word
);
    localparam int LINE_WORDS = 2 * HALF_WORDS;
    localparam int WB         = $clog2(LINE_WORDS);
    localparam int HB         = $clog2(HALF_WORDS);
    localparam int LB         = WB + 2;
    localparam int LW         = AW - LB;
    localparam int NBUF       = 3;
    localparam logic [HB-1:0] LAST_OFF = HB'(HALF_WORDS - 2);

    typedef struct packed {
        logic                     v;
        logic [LW-1:0]            line;
        logic                     half;
        logic [HB-1:0]            st;
        logic [HB-1:0]            off;
        logic [HALF_WORDS*DW-1:0] data;
    } ppb_t;

    typedef struct packed {
        ppb_t          ppb;
        logic          src_h2;
        logic          sb;
        logic          sh;
        logic          req_v;
        logic [1:0]    req_tag;
        logic [LW-1:0] req_line;
        logic [WB-1:0] req_word;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [1:0]               lv    [NBUF];
    logic [WB-1:0]            lst   [NBUF];
    logic [LW-1:0]            lline [NBUF];
    logic [LINE_WORDS*DW-1:0] ldata [NBUF];

    logic                     ln_load     [NBUF];
    logic [1:0]               ln_clr_pre  [NBUF];
    logic                     ln_clr_post [NBUF];
    logic                     ln_mark     [NBUF];
    logic                     kill_stale;

    logic       fetch_adv, last_pair, refill_need, seq_ok, src_ok;
    logic       sel_h, hint_go, refill_go, seq_take;
    logic [1:0] cur_b;

    function automatic ppb_t ppb_from(input logic [LW-1:0] line,
                                      input logic [WB-1:0] start,
                                      input logic h,
                                      input logic [LINE_WORDS*DW-1:0] data);
        ppb_t p;
        p.v    = 1'b1;
        p.line = line;
        p.half = h;
        if (!h)                p.st = start[HB-1:0];
        else if (start[WB-1])  p.st = start[HB-1:0];
        else                   p.st = '0;
        p.off  = {p.st[HB-1:1], 1'b0};
        p.data = h ? data[LINE_WORDS*DW-1 -: HALF_WORDS*DW]
                   : data[HALF_WORDS*DW-1:0];
        return p;
    endfunction

    for (genvar g = 0; g < NBUF; g++) begin : g_line
        ilbuf_line #(
            .DW(DW), .HALF_WORDS(HALF_WORDS), .LW(LW)
        ) u_line (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (ln_load[g]),
            .load_line_i  (fill_line),
            .load_word_i  (fill_word),
            .load_data_i  (fill_data),
            .clr_pre_i    (ln_clr_pre[g]),
            .clr_post_i   (ln_clr_post[g]),
            .mark_stale_i (ln_mark[g]),
            .kill_stale_i (kill_stale),
            .valid_o      (lv[g]),
            .start_o      (lst[g]),
            .line_o       (lline[g]),
            .data_o       (ldata[g])
        );
    end

    ilbuf_timer #(.KILL_CYCLES(KILL_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (hint_go),
        .flush_i  (flush),
        .expire_o (kill_stale)
    );

    always_comb begin
        s_d       = s_q;
        s_d.req_v = 1'b0;

        fetch_adv   = fetch_req && s_q.ppb.v;
        last_pair   = (s_q.ppb.off == LAST_OFF);
        refill_need = !s_q.ppb.v || (fetch_adv && last_pair);
        cur_b       = s_q.sb ? 2'd2 : 2'd1;
        sel_h       = (!s_q.sh && !lv[cur_b][0] && lv[cur_b][1]) ? 1'b1 : s_q.sh;
        seq_ok      = lv[cur_b][sel_h];
        src_ok      = s_q.src_h2 ? lv[0][1] : seq_ok;
        hint_go     = hint_take && !redirect_valid && !flush;
        refill_go   = refill_need && src_ok && !hint_go && !flush;
        seq_take    = refill_go && !s_q.src_h2;
        prefetch_miss = refill_need && !src_ok;

        for (int b = 0; b < NBUF; b++) begin
            ln_load[b]     = fill_valid && (fill_tag == 2'(b));
            ln_clr_pre[b]  = 2'b00;
            ln_clr_post[b] = flush || ((b != 0) && mp_clear);
            ln_mark[b]     = (b != 0) && hint_go;
        end
        ln_clr_pre[0] = {2{hint_kill}};

        if (fetch_adv) begin
            s_d.ppb.off = s_q.ppb.off + HB'(2);
            if (last_pair) s_d.ppb.v = 1'b0;
        end

        if (refill_go) begin
            if (s_q.src_h2) begin
                s_d.ppb    = ppb_from(lline[0], lst[0], 1'b1, ldata[0]);
                s_d.src_h2 = 1'b0;
            end else begin
                s_d.ppb = ppb_from(lline[cur_b], lst[cur_b], sel_h, ldata[cur_b]);
                ln_clr_pre[cur_b][sel_h] = 1'b1;
                if (sel_h) begin
                    s_d.sb       = !s_q.sb;
                    s_d.sh       = 1'b0;
                    s_d.req_v    = 1'b1;
                    s_d.req_tag  = s_q.sb ? TAG_SEQ0 : TAG_SEQ1;
                    s_d.req_line = lline[cur_b] + LW'(1);
                    s_d.req_word = '0;
                end else begin
                    s_d.sh = 1'b1;
                end
            end
        end

        if (redirect_valid) begin
            s_d.req_v    = 1'b1;
            s_d.req_tag  = TAG_SEQ0;
            s_d.req_line = redirect_addr[AW-1:LB];
            s_d.req_word = redirect_addr[LB-1:2];
            s_d.src_h2   = 1'b0;
            s_d.sb       = 1'b0;
            s_d.sh       = 1'b0;
        end else if (hint_go) begin
            if (lv[0][0]) begin
                s_d.ppb    = ppb_from(lline[0], lst[0], 1'b0, ldata[0]);
                s_d.src_h2 = 1'b1;
            end else if (lv[0][1]) begin
                s_d.ppb    = ppb_from(lline[0], lst[0], 1'b1, ldata[0]);
                s_d.src_h2 = 1'b0;
            end else begin
                s_d.ppb.v  = 1'b0;
                s_d.src_h2 = 1'b0;
            end
            s_d.sb       = 1'b0;
            s_d.sh       = 1'b0;
            s_d.req_v    = 1'b1;
            s_d.req_tag  = TAG_SEQ0;
            s_d.req_line = lline[0] + LW'(1);
            s_d.req_word = '0;
        end

        if (flush) begin
            s_d.ppb.v  = 1'b0;
            s_d.src_h2 = 1'b0;
            s_d.sb     = 1'b0;
            s_d.sh     = 1'b0;
            s_d.req_v  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pair_valid[0] = s_q.ppb.v && (s_q.ppb.off >= s_q.ppb.st);
    assign pair_valid[1] = s_q.ppb.v && ((s_q.ppb.off + HB'(1)) >= s_q.ppb.st);
    assign pair_addr     = {s_q.ppb.line, s_q.ppb.half, s_q.ppb.off, 2'b00};
    assign pair_data     = s_q.ppb.data[s_q.ppb.off*DW +: 2*DW];
    assign req_valid     = s_q.req_v;
    assign req_tag       = s_q.req_tag;
    assign req_line      = s_q.req_line;
    assign req_word      = s_q.req_word;

    logic [2*NBUF-1:0] lvf;
    logic [2:0]        take_idx;
    assign lvf      = {lv[2], lv[1], lv[0]};
    assign take_idx = {cur_b, sel_h};

    // A consumed sequential half is gone on the next cycle (R4)
    assert_seq_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_take && !ln_load[cur_b] |=> !lvf[$past(take_idx)]);

    // Upper-half move raises a follow-on request for the other buffer (R5)
    assert_follow_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_take && sel_h && !redirect_valid |=>
        req_valid && (req_tag == ($past(s_q.sb) ? 2'd1 : 2'd2)));

    // Hint take leaves the hint lower half valid (R6)
    assert_hint_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hint_go && lv[0][0] && !hint_kill && !ln_load[0] |=> lv[0][0]);

    // Flush leaves nothing to show and nothing requested (R8)
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pair_valid == 2'b00) && !req_valid && (lvf == '0));

    // A miss without a hint take leaves the staging buffer empty (R12)
    assert_miss_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        prefetch_miss && !hint_go |=> (pair_valid == 2'b00));
endmodule

// File: tb/ilbuf_ctrl_bench.sv
module ilbuf_ctrl_bench;
    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_valid;
    logic [1:0]    fill_tag;
    logic [10:0]   fill_line;
    logic [4:0]    fill_word;
    logic [1023:0] fill_data;
    logic          hint_take, hint_kill, redirect_valid, mp_clear, flush, fetch_req;
    logic [17:0]   redirect_addr;
    logic [1:0]    pair_valid;
    logic [17:0]   pair_addr;
    logic [63:0]   pair_data;
    logic          prefetch_miss, req_valid;
    logic [1:0]    req_tag;
    logic [10:0]   req_line;
    logic [4:0]    req_word;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ilbuf_ctrl u_ilbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_line(fill_line), .fill_word(fill_word), .fill_data(fill_data),
        .hint_take(hint_take), .hint_kill(hint_kill), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .mp_clear(mp_clear), .flush(flush),
        .fetch_req(fetch_req), .pair_valid(pair_valid), .pair_addr(pair_addr),
        .pair_data(pair_data), .prefetch_miss(prefetch_miss), .req_valid(req_valid),
        .req_tag(req_tag), .req_line(req_line), .req_word(req_word)
    );

    // word (5b) | expected byte offset in line (7b) | expected pair_valid (2b)
    localparam logic [13:0] ALIGN_VEC [5] = '{
        {5'd0,  7'h00, 2'b11},
        {5'd6,  7'h18, 2'b11},
        {5'd7,  7'h18, 2'b10},
        {5'd17, 7'h40, 2'b10},
        {5'd31, 7'h78, 2'b10}
    };

    function automatic logic [31:0] wval(input logic [10:0] line, input int idx);
        return 32'h5A00_0000 | (32'(line) << 8) | 32'(idx);
    endfunction

    function automatic logic [1023:0] mkline(input logic [10:0] line);
        logic [1023:0] v;
        for (int i = 0; i < 32; i++) v[i*32 +: 32] = wval(line, i);
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [1:0] tag, input logic [10:0] line, input logic [4:0] w);
        fill_valid = 1'b1; fill_tag = tag; fill_line = line; fill_word = w;
        fill_data  = mkline(line);
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic pulse_flush();   flush = 1'b1;     tick(); flush = 1'b0;     endtask
    task automatic pulse_take();    hint_take = 1'b1; tick(); hint_take = 1'b0; endtask
    task automatic fetch_n(input int n);
        fetch_req = 1'b1;
        repeat (n) tick();
        fetch_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fill_valid = 0; fill_tag = 0; fill_line = 0; fill_word = 0;
        fill_data = '0; hint_take = 0; hint_kill = 0; redirect_valid = 0;
        redirect_addr = '0; mp_clear = 0; flush = 0; fetch_req = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pair_valid", 64'(pair_valid), 64'd0);
        check("R1 req_valid", 64'(req_valid), 64'd0);
        check("R1 prefetch_miss", 64'(prefetch_miss), 64'd1);

        // R2 alignment table
        for (int i = 0; i < 5; i++) begin
            pulse_flush();
            do_fill(2'd1, 11'h15, ALIGN_VEC[i][13:9]);
            tick();
            check("R2 pair_addr", 64'(pair_addr), 64'(18'hA80 + ALIGN_VEC[i][8:2]));
            check("R2 pair_valid", 64'(pair_valid), 64'(ALIGN_VEC[i][1:0]));
        end

        // R3/R4/R5/R12 sequential stream
        pulse_flush();
        do_fill(2'd1, 11'h10, 5'd0);
        tick();
        check("R3 first addr", 64'(pair_addr), 64'h800);
        check("R3 first data", pair_data, {wval(11'h10, 1), wval(11'h10, 0)});
        for (int k = 1; k < 8; k++) begin
            fetch_n(1);
            check("R3 advance", 64'(pair_addr), 64'(18'h800 + 8 * k));
        end
        check("R3 data word 15", pair_data, {wval(11'h10, 15), wval(11'h10, 14)});
        fetch_n(1);
        check("R4 buffer0 upper next", 64'(pair_addr), 64'h840);
        check("R4 no gap", 64'(pair_valid), 64'd3);
        check("R5 req_valid", 64'(req_valid), 64'd1);
        check("R5 req_tag", 64'(req_tag), 64'd2);
        check("R5 req_line", 64'(req_line), 64'h11);
        check("R5 req_word", 64'(req_word), 64'd0);
        fetch_n(8);
        check("R12 empty", 64'(pair_valid), 64'd0);
        check("R12 miss", 64'(prefetch_miss), 64'd1);
        do_fill(2'd2, 11'h11, 5'd0);
        tick();
        check("R4 buffer1 lower", 64'(pair_addr), 64'h880);
        fetch_n(8);
        check("R4 buffer1 upper", 64'(pair_addr), 64'h8C0);
        check("R5 req back to buffer0", 64'(req_tag), 64'd1);
        check("R5 req_line next", 64'(req_line), 64'h12);
        fetch_n(8);
        check("R4 buffer0 emptied", 64'(pair_valid), 64'd0);

        // R6 hint take
        pulse_flush();
        do_fill(2'd0, 11'h20, 5'd6);
        check("R6 hint fill alone shows nothing", 64'(pair_valid), 64'd0);
        pulse_take();
        check("R6 hint addr", 64'(pair_addr), 64'h1018);
        check("R6 hint data", pair_data, {wval(11'h20, 7), wval(11'h20, 6)});
        check("R6 hint req_tag", 64'(req_tag), 64'd1);
        check("R6 hint req_line", 64'(req_line), 64'h21);
        fetch_n(5);
        check("R6 hint upper", 64'(pair_addr), 64'h1040);
        fetch_n(8);
        check("R6 then sequential empty", 64'(pair_valid), 64'd0);
        pulse_take();
        check("R6 hint kept", 64'(pair_addr), 64'h1018);
        check("R6 hint kept valid", 64'(pair_valid), 64'd3);

        // R7 hint kill
        hint_kill = 1'b1; tick(); hint_kill = 1'b0;
        pulse_take();
        check("R7 killed hint", 64'(pair_valid), 64'd0);
        check("R7 miss", 64'(prefetch_miss), 64'd1);

        // R9 mispredict clear
        pulse_flush();
        do_fill(2'd0, 11'h40, 5'd0);
        do_fill(2'd1, 11'h30, 5'd0);
        tick();
        check("R9 setup", 64'(pair_addr), 64'h1800);
        mp_clear = 1'b1; tick(); mp_clear = 1'b0;
        fetch_n(8);
        check("R9 sequential cleared", 64'(pair_valid), 64'd0);
        pulse_take();
        check("R9 hint survives", 64'(pair_addr), 64'h2000);
        check("R9 hint survives valid", 64'(pair_valid), 64'd3);

        // R8 flush
        pulse_flush();
        check("R8 pair cleared", 64'(pair_valid), 64'd0);
        check("R8 req cleared", 64'(req_valid), 64'd0);
        check("R8 miss", 64'(prefetch_miss), 64'd1);
        pulse_take();
        check("R8 hint cleared", 64'(pair_valid), 64'd0);

        // R10 timed kill, refill on the 8th edge then on the 9th
        for (int n = 6; n <= 7; n++) begin
            pulse_flush();
            do_fill(2'd0, 11'h40, 5'd28);
            do_fill(2'd1, 11'h30, 5'd0);
            tick();
            pulse_take();
            check("R10 hint upper only", 64'(pair_addr), 64'h2070);
            repeat (n) tick();
            fetch_n(2);
            if (n == 6) begin
                check("R10 edge 8 still valid", 64'(pair_valid), 64'd3);
                check("R10 edge 8 addr", 64'(pair_addr), 64'h1840);
            end else begin
                check("R10 edge 9 killed", 64'(pair_valid), 64'd0);
            end
        end

        // R11 redirect
        pulse_flush();
        redirect_addr = 18'h1234; redirect_valid = 1'b1; tick(); redirect_valid = 1'b0;
        check("R11 req_valid", 64'(req_valid), 64'd1);
        check("R11 req_tag", 64'(req_tag), 64'd1);
        check("R11 req_line", 64'(req_line), 64'h24);
        check("R11 req_word", 64'(req_word), 64'd13);
        tick();
        check("R11 one-cycle request", 64'(req_valid), 64'd0);
        do_fill(2'd1, 11'h24, 5'd13);
        tick();
        check("R11 redirect pair", 64'(pair_addr), 64'h1230);
        check("R11 redirect pair_valid", 64'(pair_valid), 64'd2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule